// File: doc/BRIEF.md
# Asynchronous SRAM cycle generator

This block sits on the synchronous side of a byte-wide asynchronous static memory. Single-byte read or write requests arrive on a valid/ready handshake. Each accepted request becomes one complete memory bus cycle: the block drives the address, the active-low chip enable, write enable and output enable, and the write data with its driver enable. For a read it also captures the returned byte. Every memory timing limit is given as a parameter in nanoseconds. The block turns each limit into a clock count using a clock-period parameter, so one netlist can be retargeted to another clock or to another memory speed grade.

A power-good input guards the memory. A request presented while power-good is low is consumed without any bus activity and is answered with a one-clock error pulse. A cycle that has already started always runs to completion, so the memory never sees a truncated write pulse. Only one request is in flight at a time, and bursts are not supported.

Top module: `sram_cycle_gen`

## Requirements
- R1: While reset is held and right after it is released, req_ready_o is 1; mem_ce_no, mem_we_no and mem_oe_no are 1; mem_dq_oe_o, rsp_valid_o and err_o are 0.
- R2: Each phase lasts max(1, ceil(t_ns / CLK_NS)) clocks. The active strobe phase of a read lasts the larger of the counts for access time and output-enable time (9 clocks at defaults). The active phase of a write lasts the larger of the counts for write pulse width and data setup time (7 clocks at defaults). CE stays low for exactly that many clocks.
- R3: During a write, CE and WE are low together for the whole active phase, and OE stays high. mem_addr_o does not change while CE is low.
- R4: Write data is driven (mem_dq_oe_o = 1) from the clock in which WE falls through the clock in which WE rises, and for that clock the drivers are still on. They are released afterwards. The drivers are never on while OE is low.
- R5: A read captures mem_dq_i at the last clock of its active phase. rsp_valid_o is high for exactly one clock, starting at the edge where CE and OE rise. At defaults it is first seen 11 clocks after the accepting edge.
- R6: A write runs setup, active, one-clock hold and recovery phases. Recovery is at least ceil(T_WR_NS / CLK_NS) clocks, and it is stretched so that the whole cycle lasts at least ceil(T_RC_NS / CLK_NS) clocks. At defaults req_ready_o is seen again 11 clocks after the accepting edge.
- R7: req_ready_o is high only while no cycle is in progress, and it is low in the clock after a request is accepted.
- R8: A request taken (valid and ready) while pwr_good_i is 0 starts no bus cycle, leaves the memory contents unchanged and makes err_o 1 in the following clock. req_ready_o stays 1.
- R9: Once a cycle has been accepted, a later drop of pwr_good_i does not shorten or cancel it. A write accepted before the drop is stored.
- R10: Every bus cycle meets the memory limits: cycle time 70 ns, write overlap 55 ns, data setup 30 ns, recovery 5 ns after WE rises, and read data valid 70 ns after CE and address and 35 ns after OE. Every read returns the last byte written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken this clock |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| pwr_good_i | input | 1 | Supply in tolerance; low rejects new requests |
| rsp_valid_o | output | 1 | One-clock pulse, read data valid |
| rsp_rdata_o | output | DATA_W | Captured read byte |
| err_o | output | 1 | One-clock pulse, request rejected for low power |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Write data toward the memory |
| mem_dq_oe_o | output | 1 | Write data driver enable |
| mem_dq_i | input | DATA_W | Read data from the memory |

## Verification
The two functions that can fall in the same clock are the power-good lockout and request acceptance. The bench lowers pwr_good_i on the very negative edge where it presents a request, and it expects an error pulse, no chip-enable fall and unchanged memory on read-back. It also lowers power-good a few clocks after a write has been accepted, and it expects that write to complete under the timing checks of the memory model and to be read back once power returns. Random traffic with occasional power dips repeats both cases against a scoreboard.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACT,
    PH_HOLD,
    PH_REC
  } phase_e;

  // ceil(t/clk), never below one clock
  function automatic int ns_to_clk(int t_ns, int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // clocks still needed to reach the minimum cycle length
  function automatic int fill_to(int total, int used);
    return (total > used) ? (total - used) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int N_AS     = 1,
  parameter int N_RD     = 9,
  parameter int N_WP     = 7,
  parameter int N_DH     = 1,
  parameter int N_REC_WR = 1,
  parameter int N_REC_RD = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             pwr_good_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             reject_o,
  output logic             ce_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o,
  output logic             capture_o
);

  phase_e ph_q, ph_d;
  logic   wr_q;

  assign ready_o  = (ph_q == PH_IDLE);
  assign accept_o = ready_o && req_valid_i && pwr_good_i;
  assign reject_o = ready_o && req_valid_i && !pwr_good_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (accept_o) ph_d = PH_SETUP;
      PH_SETUP: if (last_i) ph_d = PH_ACT;
      PH_ACT:   if (last_i) ph_d = wr_q ? PH_HOLD : PH_REC;
      PH_HOLD:  if (last_i) ph_d = PH_REC;
      PH_REC:   if (last_i) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  assign load_o = (ph_d != ph_q);

  always_comb begin
    unique case (ph_d)
      PH_SETUP: len_o = CNT_W'(N_AS);
      PH_ACT:   len_o = wr_q || (ph_q == PH_IDLE && req_write_i)
                        ? CNT_W'(N_WP) : CNT_W'(N_RD);
      PH_HOLD:  len_o = CNT_W'(N_DH);
      PH_REC:   len_o = wr_q ? CNT_W'(N_REC_WR) : CNT_W'(N_REC_RD);
      default:  len_o = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;
      wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept_o) wr_q <= req_write_i;
    end
  end

  assign ce_n_o    = !(ph_q == PH_ACT);
  assign we_n_o    = !(ph_q == PH_ACT && wr_q);
  assign oe_n_o    = !(ph_q == PH_ACT && !wr_q);
  assign dq_oe_o   = wr_q && (ph_q == PH_ACT || ph_q == PH_HOLD);
  assign capture_o = (ph_q == PH_ACT) && !wr_q && last_i;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) data_o <= dq_i;
    end
  end

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sram_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_RC_NS  = 70,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WP_NS  = 55,
  parameter int T_AS_NS  = 0,
  parameter int T_DS_NS  = 30,
  parameter int T_DH_NS  = 0,
  parameter int T_WR_NS  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              pwr_good_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_AS     = ns_to_clk(T_AS_NS, CLK_NS);
  localparam int N_RD     = max2(ns_to_clk(T_ACC_NS, CLK_NS), ns_to_clk(T_OE_NS, CLK_NS));
  localparam int N_WP     = max2(ns_to_clk(T_WP_NS, CLK_NS), ns_to_clk(T_DS_NS, CLK_NS));
  localparam int N_DH     = ns_to_clk(T_DH_NS, CLK_NS);
  localparam int N_RC     = ns_to_clk(T_RC_NS, CLK_NS);
  localparam int N_REC_WR = max2(ns_to_clk(T_WR_NS, CLK_NS), fill_to(N_RC, N_AS + N_WP + N_DH));
  localparam int N_REC_RD = fill_to(N_RC, N_AS + N_RD);
  localparam int N_MAX    = max2(max2(max2(N_AS, N_RD), max2(N_WP, N_DH)),
                                 max2(N_REC_WR, N_REC_RD));
  localparam int CNT_W    = $clog2(N_MAX + 1);

  logic             load, last, accept, reject, capture;
  logic [CNT_W-1:0] len;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q;

  sram_cycle_fsm #(
    .CNT_W(CNT_W), .N_AS(N_AS), .N_RD(N_RD), .N_WP(N_WP), .N_DH(N_DH),
    .N_REC_WR(N_REC_WR), .N_REC_RD(N_REC_RD)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .pwr_good_i (pwr_good_i),
    .last_i     (last),
    .load_o     (load),
    .len_o      (len),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .reject_o   (reject),
    .ce_n_o     (mem_ce_no),
    .we_n_o     (mem_we_no),
    .oe_n_o     (mem_oe_no),
    .dq_oe_o    (mem_dq_oe_o),
    .capture_o  (capture)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .last_o(last)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .dq_i     (mem_dq_i),
    .valid_o  (rsp_valid_o),
    .data_o   (rsp_rdata_o)
  );

  // address and data held from acceptance to the end of the cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign err_o      = err_q;

endmodule

// File: rtl/sram_cycle_gen_chk.sv
module sram_cycle_gen_chk
  import sram_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int CLK_NS   = 8,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WP_NS  = 55,
  parameter int T_DS_NS  = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_dq_oe_o
);

  localparam int C_RD = max2(ns_to_clk(T_ACC_NS, CLK_NS), ns_to_clk(T_OE_NS, CLK_NS));
  localparam int C_WP = max2(ns_to_clk(T_WP_NS, CLK_NS), ns_to_clk(T_DS_NS, CLK_NS));

  logic [15:0] ce_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ce_run <= '0;
    else if (mem_ce_no)        ce_run <= '0;
    else if (ce_run != 16'hffff) ce_run <= ce_run + 1'b1;
  end

  p_ce_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (ce_run == ($past(mem_we_no) ? 16'(C_RD) : 16'(C_WP))));

  p_oe_off_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && !mem_ce_no));

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));

  p_drv_past_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  p_no_drive_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);

  p_rsp_at_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_ce_no) && $past(mem_we_no)) |-> rsp_valid_o);

  p_rsp_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o);

  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mem_ce_no && req_ready_o));

endmodule

bind sram_cycle_gen sram_cycle_gen_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_ACC_NS(T_ACC_NS), .T_OE_NS(T_OE_NS),
  .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .err_o      (err_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_we_no  (mem_we_no),
  .mem_oe_no  (mem_oe_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/tb_sram_cycle_gen.sv
`timescale 1ns/100ps
module tb_sram_cycle_gen;

  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int CLK = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pwr_good = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, err;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i = '0;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK/2) clk = ~clk;

  sram_cycle_gen #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .pwr_good_i(pwr_good),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .err_o(err),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n),
    .mem_oe_no(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // expected phase lengths from the requirements
  function automatic int clks(int t);
    int c;
    c = (t + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction
  function automatic logic [DW-1:0] init_val(int a);
    return DW'(a * 37 + 11);
  endfunction

  localparam int E_AS  = 1;
  localparam int E_RD  = 9;   // max(ceil 70/8, ceil 35/8)
  localparam int E_WP  = 7;   // max(ceil 55/8, ceil 30/8)

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing monitor
  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  int viol = 0;
  int ce_falls = 0;
  realtime last_wp_ns = 0, last_rd_ns = 0;

  initial begin
    realtime now, t_ce = -1000, t_lastce = -1000, t_oe = -1000, t_addr = -1000;
    realtime t_dq = -1000, t_wrs = 0, t_rds = 0, t_wer = -1000;
    logic p_ce = 0, p_we = 0, p_oe = 0, p_drv = 0, p_rd = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = init_val(i);
    #0.5;
    forever begin
      logic ce, we, oe, rd;
      now = $realtime;
      ce = !mem_ce_n; we = !mem_we_n; oe = !mem_oe_n;
      if (rst_n) begin
        if (ce && !p_ce) begin
          if (now - t_lastce < 70) viol++;
          if (now - t_wer < 5) viol++;
          t_ce = now; t_lastce = now; ce_falls++;
        end
        if (oe && !p_oe) t_oe = now;
        if (mem_addr != p_addr) begin
          t_addr = now;
          if (p_ce && p_we) viol++;
        end
        if (mem_dq_oe && (!p_drv || mem_dq_o != p_dq)) t_dq = now;
        if (oe && we) viol++;
        if (oe && mem_dq_oe) viol++;
        if (ce && we && !(p_ce && p_we)) t_wrs = now;
        if (p_ce && p_we && !(ce && we)) begin
          last_wp_ns = now - t_wrs;
          if (now - t_wrs < 55) viol++;
          if (now - t_dq < 30) viol++;
          if (!p_drv) viol++;
          mem_m[p_addr] = p_dq;
          t_wer = now;
        end
        rd = ce && oe && !we;
        if (rd && !p_rd) t_rds = now;
        if (!rd && p_rd) last_rd_ns = now - t_rds;
        if (rd) begin
          if ((now - t_ce >= 70) && (now - t_oe >= 35) && (now - t_addr >= 70))
            mem_dq_i = mem_m[mem_addr];
          else
            mem_dq_i = ~mem_m[mem_addr];
        end else begin
          mem_dq_i = '0;
        end
        p_rd = rd;
      end
      p_ce = ce; p_we = we; p_oe = oe; p_drv = mem_dq_oe;
      p_addr = mem_addr; p_dq = mem_dq_o;
      #1;
    end
  end

  // ---------------- request driver
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit timed);
    bit rej;
    int n;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    rej = !pwr_good;
    @(negedge clk);
    req_valid = 0;
    n = 1;
    if (rej) begin
      chk("R8 err pulse", {31'd0, err}, 1);
      chk("R8 ready kept", {31'd0, req_ready}, 1);
      return;
    end
    chk("R7 busy after accept", {31'd0, req_ready}, 0);
    if (wr) begin
      shadow[a] = d;
      while (!req_ready && n < 100) begin @(negedge clk); n++; end
      if (timed) chk("R6 write cycle length", n, 11);
    end else begin
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      if (timed) chk("R5 read latency", n, E_AS + E_RD + 1);
      chk("R10 read data", {24'd0, rsp_rdata}, {24'd0, shadow[a]});
      @(negedge clk);
      if (timed) chk("R5 rsp one clock", {31'd0, rsp_valid}, 0);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * CLK);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int falls;
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_val(i);
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, req_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 strobes idle", {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk("R1 outputs quiet", {29'd0, mem_dq_oe, rsp_valid, err}, 3'b000);

    // directed
    issue(1, 10'h000, 8'hA5, 1);
    chk("R2 write pulse ns", int'(last_wp_ns), E_WP * CLK);
    issue(0, 10'h000, 8'h00, 1);
    chk("R2 read strobe ns", int'(last_rd_ns), E_RD * CLK);
    issue(0, 10'h3FF, 8'h00, 1);          // never written
    issue(1, 10'h3FF, 8'h5A, 1);
    issue(1, 10'h3FF, 8'hC3, 1);
    issue(0, 10'h3FF, 8'h00, 1);

    // R8: power low on the same clock the request is presented
    falls = ce_falls;
    pwr_good = 0;
    issue(1, 10'h000, 8'hFF, 0);
    repeat (4) @(negedge clk);
    chk("R8 no bus cycle", ce_falls, falls);
    pwr_good = 1;
    issue(0, 10'h000, 8'h00, 0);          // still A5
    chk("R8 memory unchanged", {24'd0, mem_m[0]}, 32'hA5);

    // R9: power drops after acceptance
    fork
      issue(1, 10'h155, 8'h3C, 1);
      begin repeat (3) @(negedge clk); pwr_good = 0; end
    join
    chk("R9 write landed", {24'd0, mem_m[10'h155]}, 32'h3C);
    pwr_good = 1;
    issue(0, 10'h155, 8'h00, 0);

    // random traffic with occasional power dips
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 16);
      pwr_good = ($urandom % 10) != 0;
      issue(($urandom % 2) == 1, a, DW'($urandom), 0);
    end
    pwr_good = 1;
    repeat (20) @(negedge clk);
    chk("R10 timing violations", viol, 0);
    chk("R4 drivers idle at end", {31'd0, mem_dq_oe}, 0);
    finish_run();
  end

endmodule